// File: doc/BRIEF.md
# DDS Tuning Word Calculator

This block converts a requested output frequency and a reference clock frequency, both whole numbers of hertz, into the 48-bit phase increment that a direct digital synthesizer adds to its phase accumulator on every reference clock. The result is the exact integer part of the output frequency times 2^48 divided by the reference frequency. The block computes it with a bit-serial restoring division of an 80-bit dividend (the output frequency followed by 48 zero bits) by the 32-bit reference frequency. It produces one quotient bit per clock.

A controller places both frequencies on the inputs and pulses the start input for one cycle. The unit raises its busy output. It ignores further start pulses until the answer is ready. It then pulses done for one cycle and holds the word and the error flag on its outputs until the next accepted start. A reference frequency of zero does not divide. Instead it reports an error with an all-ones word after the same latency.

Top module: `dds_tuning_calc`

## Requirements
- R1: For fclk_i not zero, word_o equals the low 48 bits of floor(fout_i × 2^48 / fclk_i), with fout_i and fclk_i read as unsigned 32-bit integers at the accepted start.
- R2: With fclk_i = 100,000,000 and fout_i = 11,300,000 the word is 0x1CED916872B0.
- R3: A start is accepted on a rising clock edge where start_i is high and busy_o is low. done_o is high for exactly one cycle, starting at the 80th rising edge after the accepting edge.
- R4: busy_o goes high at the accepting edge, stays high through every cycle in between, and is low in the cycle where done_o is high.
- R5: A start_i pulse while busy_o is high has no effect: it produces no extra done_o, and the operands of the running division are kept.
- R6: With fclk_i = 0, err_o is high and word_o is all ones when done_o rises, with the same latency. err_o is low at the done of any division with a non-zero fclk_i, and it clears at the next accepted start.
- R7: When fout_i ≥ fclk_i the result is truncated to the low 48 quotient bits. For example, 3 over 2 gives 0x800000000000, and equal operands give 0.
- R8: While rst_ni is low and after it is released, busy_o, done_o and err_o are low and word_o is zero.
- R9: word_o keeps its last result, unchanged, from one done_o until the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| fout_i | input | 32 | Wanted output frequency in Hz |
| fclk_i | input | 32 | Reference clock frequency in Hz |
| word_o | output | 48 | Tuning word result |
| done_o | output | 1 | One-cycle result strobe |
| busy_o | output | 1 | Division in progress |
| err_o | output | 1 | Zero reference frequency reported |

## Verification
The known reference case (100 MHz, 11.3 MHz) and a zero numerator confirm that the shift order and the quotient assembly are right. Numerators just below the divisor, and a divisor of 1 or of 2^32−1, drive the partial remainder to its extremes, where a wrong restore decision or a lost carry bit would show. Operands at or above the divisor separate correct truncation from overflow handling. A zero divisor followed by a normal run shows whether the error flag sets and then clears. A pseudo-random series of operands runs back to back, which tests that each run starts from a clean remainder. A start pulse with different operands injected mid-run shows whether the running operands are protected and whether an extra result appears.

// File: rtl/dds_tw_pkg.sv
package dds_tw_pkg;
  parameter int unsigned DEF_FREQ_W = 32;
  parameter int unsigned DEF_FRAC_W = 48;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tw_state_e;
endpackage

// File: rtl/dds_tw_ctrl.sv
module dds_tw_ctrl
  import dds_tw_pkg::*;
#(
  parameter int unsigned STEPS = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(STEPS);

  tw_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign busy_o = (state_q == ST_RUN);
  assign load_o = start_i && (state_q == ST_IDLE);
  assign step_o = busy_o;
  assign last_o = busy_o && (cnt_q == CNT_W'(STEPS - 1));
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_o;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (last_o) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_busy_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_o) |=> busy_o);
  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (32'(cnt_q) < STEPS));
endmodule

// File: rtl/dds_tw_div_step.sv
module dds_tw_div_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic         bit_i,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] rem_o,
  output logic         q_o
);
  logic [W:0]   shifted;
  logic [W+1:0] diff;

  // rem_i < div_i keeps shifted < 2*div_i, so either branch fits W bits
  always_comb begin
    shifted = {rem_i, bit_i};
    diff    = {1'b0, shifted} - {2'b00, div_i};
    q_o     = ~diff[W+1];
    rem_o   = q_o ? diff[W-1:0] : shifted[W-1:0];
  end
endmodule

// File: rtl/dds_tw_datapath.sv
module dds_tw_datapath #(
  parameter int unsigned FREQ_W = 32,
  parameter int unsigned FRAC_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              last_i,
  input  logic [FREQ_W-1:0] fout_i,
  input  logic [FREQ_W-1:0] fclk_i,
  output logic [FRAC_W-1:0] word_o,
  output logic              err_o
);
  localparam int unsigned NUM_W = FREQ_W + FRAC_W;

  logic [FREQ_W-1:0] div_q, rem_q, rem_nxt;
  logic [NUM_W-1:0]  acc_q, acc_nxt;
  logic [FRAC_W-1:0] word_q;
  logic              err_q, q_bit, div_zero;

  dds_tw_div_step #(.W(FREQ_W)) u_step (
    .rem_i (rem_q),
    .bit_i (acc_q[NUM_W-1]),
    .div_i (div_q),
    .rem_o (rem_nxt),
    .q_o   (q_bit)
  );

  // dividend bits leave at the top, quotient bits enter at the bottom
  assign acc_nxt  = {acc_q[NUM_W-2:0], q_bit};
  assign div_zero = (div_q == '0);
  assign word_o   = word_q;
  assign err_o    = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      rem_q  <= '0;
      acc_q  <= '0;
      word_q <= '0;
      err_q  <= 1'b0;
    end else if (load_i) begin
      div_q <= fclk_i;
      rem_q <= '0;
      acc_q <= {fout_i, {FRAC_W{1'b0}}};
      err_q <= 1'b0;
    end else if (step_i) begin
      rem_q <= rem_nxt;
      acc_q <= acc_nxt;
      if (last_i) begin
        err_q  <= div_zero;
        word_q <= div_zero ? {FRAC_W{1'b1}} : acc_nxt[FRAC_W-1:0];
      end
    end
  end

  assert_rem_below_div_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !div_zero) |-> (rem_q < div_q));
  assert_operands_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> $stable(div_q));
  assert_zero_div_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && div_zero) |=> (err_o && (&word_o)));
  assert_word_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(word_o));
endmodule

// File: rtl/dds_tuning_calc.sv
module dds_tuning_calc
  import dds_tw_pkg::*;
#(
  parameter int unsigned FREQ_W = DEF_FREQ_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] fout_i,
  input  logic [FREQ_W-1:0] fclk_i,
  output logic [FRAC_W-1:0] word_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              err_o
);
  localparam int unsigned STEPS = FREQ_W + FRAC_W;

  logic load, step, last;

  dds_tw_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  dds_tw_datapath #(.FREQ_W(FREQ_W), .FRAC_W(FRAC_W)) u_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .last_i (last),
    .fout_i (fout_i),
    .fclk_i (fclk_i),
    .word_o (word_o),
    .err_o  (err_o)
  );

  assert_result_with_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: tb/dds_tuning_calc_tb.sv
module dds_tuning_calc_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] fout_i = '0;
  logic [31:0] fclk_i = '0;
  logic [47:0] word_o;
  logic        done_o, busy_o, err_o;

  dds_tuning_calc u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .fout_i(fout_i), .fclk_i(fclk_i),
    .word_o(word_o), .done_o(done_o), .busy_o(busy_o), .err_o(err_o)
  );

  always #4 clk_i = ~clk_i;

  typedef struct {
    logic [47:0] word;
    logic        err;
    longint      c0;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          errors = 0;
  longint      cyc = 0;
  logic [47:0] prev_word = '0;
  logic        prev_err = 1'b0;
  logic        done_seen = 1'b0;
  logic        mon_en = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] ref_word(input logic [31:0] fo, input logic [31:0] fc);
    logic [127:0] n, q;
    if (fc == 0) return '1;
    n = {48'b0, fo, 48'b0};
    q = n / {96'b0, fc};
    return q[47:0];
  endfunction

  task automatic run(input logic [31:0] fo, input logic [31:0] fc, input string tag);
    exp_t e;
    while (busy_o) @(negedge clk_i);
    e.word = ref_word(fo, fc);
    e.err  = (fc == 0);
    e.c0   = cyc;
    e.tag  = tag;
    sb_q.push_back(e);
    fout_i  = fo;
    fclk_i  = fc;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R4 busy after start", 64'(busy_o), 64'd1);
    chk(word_o == prev_word, "R9 word held", 64'(word_o), 64'(prev_word));
    if (prev_err) chk(err_o == 1'b0, "R6 err cleared on start", 64'(err_o), 64'd0);
    prev_word = e.word;
    prev_err  = e.err;
  endtask

  // monitor: pops the scoreboard on every result strobe
  always @(negedge clk_i) begin
    if (mon_en) begin
      if (done_seen) chk(done_o == 1'b0, "R3 done one cycle", 64'(done_o), 64'd0);
      if (done_o) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R5 unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(word_o == e.word, e.tag, 64'(word_o), 64'(e.word));
          chk(err_o == e.err, "R6 err flag", 64'(err_o), 64'(e.err));
          chk((cyc - e.c0) == 81, "R3 latency", 64'(cyc - e.c0), 64'd81);
          chk(busy_o == 1'b0, "R4 busy low at done", 64'(busy_o), 64'd0);
        end
      end
      done_seen <= done_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o, err_o} == 3'b000, "R8 flags in reset", 64'({busy_o, done_o, err_o}), 64'd0);
    chk(word_o == '0, "R8 word in reset", 64'(word_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({busy_o, done_o, err_o} == 3'b000, "R8 flags after reset", 64'({busy_o, done_o, err_o}), 64'd0);
    mon_en = 1'b1;

    run(32'd11_300_000, 32'd100_000_000, "R2 reference case");
    run(32'd0, 32'd100_000_000, "R1 zero numerator");
    run(32'hFFFF_FFFE, 32'hFFFF_FFFF, "R1 numerator just below divisor");
    run(32'd1, 32'hFFFF_FFFF, "R1 max divisor");
    run(32'd0, 32'd1, "R1 unit divisor");
    run(32'd3, 32'd2, "R7 truncation 3/2");
    run(32'd5, 32'd5, "R7 equal operands");
    run(32'd7, 32'd0, "R6 zero divisor");
    run(32'd1, 32'd3, "R1 after error");

    for (int i = 0; i < 16; i++) begin
      logic [31:0] fc, fo;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      fc = rng | 32'd1;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      fo = rng % fc;
      run(fo, fc, "R1 pseudo-random");
    end

    // R5: second start mid-run with other operands must be ignored
    run(32'd1_000_000, 32'd50_000_000, "R5 first op kept");
    repeat (10) @(negedge clk_i);
    fout_i = 32'd9; fclk_i = 32'd0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    repeat (100) @(negedge clk_i);
    chk(sb_q.size() == 0, "R5 no pending results", 64'(sb_q.size()), 64'd0);
    chk(word_o == prev_word, "R9 word held idle", 64'(word_o), 64'(prev_word));
    chk(busy_o == 1'b0, "R5 no restart", 64'(busy_o), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule